// File: doc/BRIEF.md
# Processing-State Sequencer

This block tracks which of five processing modes a small processor core is in and drives the control lines that go with that mode. A low level on the reset pin forces the reset mode at once, from any mode. When the pin is released, the sequencer runs reset exception handling: it reads the reset entry of the vector table over a simple read port and hands the fetched address to the core as a branch target. A watchdog overflow pulse forces the same path.

When the core is running, four kinds of request are considered, in a fixed priority order. From highest to lowest they are watchdog overflow, a bus request from another master, an exception request carrying a two-bit source code, and a sleep strobe or hardware-standby level. A bus request releases the bus and halts the core. An exception request starts a vector fetch at a table base plus four times the source code. Sleep or standby stops the core. The sequencer leaves the stop mode in one of two ways. If it entered on sleep, an interrupt request ends the stop. If it entered on standby, release of the standby level ends it.

Top module: `proc_state_seq`

## Requirements
- R1: The mode output uses the codes reset=0, exception=1, execute=2, bus released=3, stop=4. Exception source codes are reset=0, trace=1, interrupt=2, trap=3.
- R2: While `rstN` is low, the mode is reset. The pin takes effect without waiting for a clock edge. `intMask` and `coreHalt` read 1, and `vecRd` and `busGrant` read 0.
- R3: On the first clock edge after `rstN` goes high, the mode becomes exception with source reset, so `vecAddr` equals `VEC_BASE`.
- R4: A `wdtOvf` pulse puts the mode into reset on the next edge, whatever the mode was. The sequencer then proceeds as in R3.
- R5: In the exception mode, `vecRd` is 1 and `vecAddr` equals `VEC_BASE + 4*source`, where source is the code that was latched on entry.
- R6: `vecRd` stays high and `vecAddr` stays unchanged until a clock edge that sees `vecRdy` high. On that edge `branchTarget` takes `vecData` and the mode becomes execute.
- R7: In the execute mode, the priority order is watchdog, then `busReq`, then `excReq`, then `sleepStb` or `hwStandby`.
- R8: The bus-released mode drives `busGrant` and `coreHalt` to 1. When `busReq` falls, the mode returns to execute on the next edge.
- R9: A sleep strobe or a standby level in the execute mode enters the stop mode. `coreHalt` is 1 in every mode except execute.
- R10: A stop entered by sleep leaves to the exception mode only on an `excReq` whose source is interrupt (2). Trace, trap and reset requests leave the mode unchanged.
- R11: A stop entered by standby ignores exception requests. It goes to reset on the edge after `hwStandby` falls.
- R12: `intMask` is 1 in the reset and exception modes. It clears when a vector fetch completes, so it reads 0 in the execute, bus-released and stop modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset pin, asynchronous |
| wdtOvf | input | 1 | Watchdog overflow pulse |
| excReq | input | 1 | Exception request |
| excSrc | input | 2 | Exception source code |
| busReq | input | 1 | Bus request from another master |
| sleepStb | input | 1 | Sleep instruction strobe |
| hwStandby | input | 1 | Hardware standby level |
| vecRdy | input | 1 | Vector read data valid |
| vecData | input | DATA_W | Vector read data |
| vecRd | output | 1 | Vector read strobe |
| vecAddr | output | ADDR_W | Vector table address |
| branchTarget | output | DATA_W | Fetched start address |
| procState | output | 3 | Current mode code |
| intMask | output | 1 | Interrupt mask flag |
| coreHalt | output | 1 | Core halt |
| busGrant | output | 1 | Bus released to another master |

## Verification
The assertions check the following on every cycle:
- a watchdog pulse always lands in the reset mode;
- a granted bus always comes with a halted core;
- the vector read is held steady while it waits for ready;
- the target register changes only when a fetch completes;
- the mask is set whenever the mode is reset.

Some behaviour only the bench's scenarios can show: the priority when several requests arrive together, the way the stop mode remembers its cause, the vector offsets for each source, and the immediate effect of the reset pin between clock edges. The bench shows these by comparing every output against a behavioural model on each clock.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_EXCEPT = 3'd1,
    ST_EXEC   = 3'd2,
    ST_BUSREL = 3'd3,
    ST_STOP   = 3'd4
  } procState_t;

  localparam int SRC_W = 2;
  localparam logic [SRC_W-1:0] SRC_RESET = 2'd0;
  localparam logic [SRC_W-1:0] SRC_TRACE = 2'd1;
  localparam logic [SRC_W-1:0] SRC_IRQ   = 2'd2;
  localparam logic [SRC_W-1:0] SRC_TRAP  = 2'd3;

  typedef struct packed {
    logic             latchSrc;
    logic [SRC_W-1:0] srcVal;
    logic             loadTarget;
    logic             setMask;
    logic             clrMask;
  } dpCtrl_t;
endpackage

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wdtOvf,
  input  logic             excReq,
  input  logic [SRC_W-1:0] excSrc,
  input  logic             busReq,
  input  logic             sleepStb,
  input  logic             hwStandby,
  input  logic             vecRdy,
  output procState_t       state,
  output dpCtrl_t          dpCtrl
);
  procState_t nextState;
  logic       stopByStby, nextStopByStby;

  always_comb begin
    nextState      = state;
    nextStopByStby = stopByStby;
    dpCtrl         = '0;
    if (wdtOvf) begin
      nextState = ST_RESET;
    end else begin
      unique case (state)
        ST_RESET: begin
          nextState       = ST_EXCEPT;
          dpCtrl.latchSrc = 1'b1;
          dpCtrl.srcVal   = SRC_RESET;
        end
        ST_EXCEPT: begin
          if (vecRdy) begin
            nextState         = ST_EXEC;
            dpCtrl.loadTarget = 1'b1;
            dpCtrl.clrMask    = 1'b1;
          end
        end
        ST_EXEC: begin
          if (busReq) begin
            nextState = ST_BUSREL;
          end else if (excReq) begin
            nextState       = ST_EXCEPT;
            dpCtrl.latchSrc = 1'b1;
            dpCtrl.srcVal   = excSrc;
          end else if (sleepStb || hwStandby) begin
            nextState      = ST_STOP;
            nextStopByStby = hwStandby;
          end
        end
        ST_BUSREL: begin
          if (!busReq) nextState = ST_EXEC;
        end
        ST_STOP: begin
          if (stopByStby) begin
            if (!hwStandby) nextState = ST_RESET;
          end else if (excReq && excSrc == SRC_IRQ) begin
            nextState       = ST_EXCEPT;
            dpCtrl.latchSrc = 1'b1;
            dpCtrl.srcVal   = SRC_IRQ;
          end
        end
        default: nextState = ST_RESET;
      endcase
    end
    dpCtrl.setMask = (nextState == ST_RESET) || (nextState == ST_EXCEPT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_RESET;
      stopByStby <= 1'b0;
    end else begin
      state      <= nextState;
      stopByStby <= nextStopByStby;
    end
  end

  a_r4_wdt_reset: assert property (@(posedge clk) disable iff (!rstN)
    wdtOvf |=> state == ST_RESET);
  a_r8_bus_return: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_BUSREL && !busReq && !wdtOvf) |=> state == ST_EXEC);
  a_r11_stby_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STOP && stopByStby && hwStandby && !wdtOvf) |=> state == ST_STOP);
endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] vecData,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [DATA_W-1:0] branchTarget,
  output logic              intMask
);
  localparam int ENTRY_SH = 2;

  logic [SRC_W-1:0] srcReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg       <= SRC_RESET;
      branchTarget <= '0;
      intMask      <= 1'b1;
    end else begin
      if (dpCtrl.latchSrc)   srcReg       <= dpCtrl.srcVal;
      if (dpCtrl.loadTarget) branchTarget <= vecData;
      if (dpCtrl.setMask)    intMask      <= 1'b1;
      else if (dpCtrl.clrMask) intMask    <= 1'b0;
    end
  end

  assign vecAddr = VEC_BASE + (ADDR_W'(srcReg) << ENTRY_SH);

  a_r6_target_load: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.loadTarget |=> branchTarget == $past(vecData));
  a_r6_target_keep: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtrl.loadTarget |=> $stable(branchTarget));
endmodule

// File: rtl/proc_state_seq.sv
module proc_state_seq
  import pss_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              DATA_W   = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE = 'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wdtOvf,
  input  logic              excReq,
  input  logic [1:0]        excSrc,
  input  logic              busReq,
  input  logic              sleepStb,
  input  logic              hwStandby,
  input  logic              vecRdy,
  input  logic [DATA_W-1:0] vecData,
  output logic              vecRd,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [DATA_W-1:0] branchTarget,
  output logic [2:0]        procState,
  output logic              intMask,
  output logic              coreHalt,
  output logic              busGrant
);
  procState_t state;
  dpCtrl_t    dpCtrl;

  pss_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wdtOvf(wdtOvf), .excReq(excReq), .excSrc(excSrc),
    .busReq(busReq), .sleepStb(sleepStb), .hwStandby(hwStandby),
    .vecRdy(vecRdy), .state(state), .dpCtrl(dpCtrl)
  );

  pss_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_BASE(VEC_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .vecData(vecData),
    .vecAddr(vecAddr), .branchTarget(branchTarget), .intMask(intMask)
  );

  assign procState = state;
  assign vecRd     = (state == ST_EXCEPT);
  assign coreHalt  = (state != ST_EXEC);
  assign busGrant  = (state == ST_BUSREL);

  a_r12_mask_in_reset: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RESET) |-> intMask);
  a_r8_grant_halts: assert property (@(posedge clk) disable iff (!rstN)
    busGrant |-> coreHalt);
  a_r6_read_held: assert property (@(posedge clk) disable iff (!rstN)
    (vecRd && !vecRdy && !wdtOvf) |=> (vecRd && $stable(vecAddr)));
endmodule

// File: tb/proc_state_seq_tb.sv
module proc_state_seq_tb;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] BASE = 'h100;

  logic clk = 1'b0;
  logic rstN = 1'b0, wdtOvf = 1'b0, excReq = 1'b0, busReq = 1'b0;
  logic sleepStb = 1'b0, hwStandby = 1'b0, vecRdy = 1'b0;
  logic [1:0] excSrc = 2'd0;
  logic [DATA_W-1:0] vecData = '0;
  logic vecRd, intMask, coreHalt, busGrant;
  logic [ADDR_W-1:0] vecAddr;
  logic [DATA_W-1:0] branchTarget;
  logic [2:0] procState;

  int errors = 0, checks = 0;
  string curTag = "R2";
  bit done = 1'b0;

  always #2 clk = ~clk;

  proc_state_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_BASE(BASE)) u_dut (
    .clk(clk), .rstN(rstN), .wdtOvf(wdtOvf), .excReq(excReq), .excSrc(excSrc),
    .busReq(busReq), .sleepStb(sleepStb), .hwStandby(hwStandby),
    .vecRdy(vecRdy), .vecData(vecData), .vecRd(vecRd), .vecAddr(vecAddr),
    .branchTarget(branchTarget), .procState(procState), .intMask(intMask),
    .coreHalt(coreHalt), .busGrant(busGrant)
  );

  // Behavioural reference: modes 0 reset,1 exception,2 execute,3 bus released,4 stop
  int mMode, mSrc;
  bit mMask, mStby;
  logic [DATA_W-1:0] mTarget;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mSrc = 0; mMask = 1; mStby = 0; mTarget = '0;
    end else if (wdtOvf) begin
      mMode = 0; mMask = 1;
    end else begin
      if (mMode == 0) begin
        mMode = 1; mSrc = 0; mMask = 1;
      end else if (mMode == 1) begin
        if (vecRdy) begin mMode = 2; mTarget = vecData; mMask = 0; end
      end else if (mMode == 2) begin
        if (busReq) mMode = 3;
        else if (excReq) begin mMode = 1; mSrc = excSrc; mMask = 1; end
        else if (sleepStb || hwStandby) begin mMode = 4; mStby = hwStandby; end
      end else if (mMode == 3) begin
        if (!busReq) mMode = 2;
      end else begin
        if (mStby) begin
          if (!hwStandby) begin mMode = 0; mMask = 1; end
        end else if (excReq && excSrc == 2'd2) begin
          mMode = 1; mSrc = 2; mMask = 1;
        end
      end
    end
  end

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", curTag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("procState", procState, mMode);
    chk("intMask", intMask, mMask);
    chk("coreHalt", coreHalt, mMode != 2);
    chk("busGrant", busGrant, mMode == 3);
    chk("vecRd", vecRd, mMode == 1);
    if (mMode == 1) chk("vecAddr", vecAddr, BASE + 4 * mSrc);
    chk("branchTarget", branchTarget, mTarget);
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic finishFetch(logic [DATA_W-1:0] d);
    vecRdy = 1'b1; vecData = d;
    cyc();
    vecRdy = 1'b0;
  endtask

  initial begin
    // R2: held reset
    cyc(3);
    chk("R2 mode code", procState, 0);
    // R3: release, reset exception fetch
    curTag = "R3"; rstN = 1'b1;
    cyc();
    chk("R3 vecAddr", vecAddr, BASE);
    // R6: wait states then ready
    curTag = "R6"; cyc(2);
    finishFetch(32'hA5A5_0001);
    cyc();
    chk("R6 target", branchTarget, 32'hA5A5_0001);
    chk("R1 exec code", procState, 2);
    // R7: all requests at once: bus wins
    curTag = "R7"; busReq = 1'b1; excReq = 1'b1; excSrc = 2'd3; sleepStb = 1'b1;
    cyc();
    chk("R7 bus first", procState, 3);
    curTag = "R8"; sleepStb = 1'b0; cyc(2);
    busReq = 1'b0; cyc();
    chk("R8 back to exec", procState, 2);
    // R5: trap request (still asserted) -> vector BASE+12
    curTag = "R5"; cyc();
    excReq = 1'b0;
    chk("R5 trap vec", vecAddr, BASE + 12);
    cyc();
    finishFetch(32'h0000_1234); cyc();
    // R7: exception beats sleep
    curTag = "R7"; excReq = 1'b1; excSrc = 2'd1; sleepStb = 1'b1;
    cyc(); excReq = 1'b0; sleepStb = 1'b0;
    chk("R7 exc over sleep", procState, 1);
    chk("R5 trace vec", vecAddr, BASE + 4);
    finishFetch(32'h0000_2000); cyc();
    // R9/R10: sleep then wake
    curTag = "R9"; sleepStb = 1'b1; cyc(); sleepStb = 1'b0;
    chk("R9 stop", procState, 4);
    curTag = "R10"; excReq = 1'b1; excSrc = 2'd1; cyc(2);
    excSrc = 2'd3; cyc(2);
    chk("R10 trap ignored", procState, 4);
    excSrc = 2'd2; cyc(); excReq = 1'b0;
    chk("R10 irq vec", vecAddr, BASE + 8);
    finishFetch(32'h0000_3000); cyc();
    // R11: standby stop
    curTag = "R11"; hwStandby = 1'b1; cyc();
    excReq = 1'b1; excSrc = 2'd2; cyc(3); excReq = 1'b0;
    chk("R11 irq ignored", procState, 4);
    hwStandby = 1'b0; cyc();
    chk("R11 to reset", procState, 0);
    cyc();
    chk("R12 mask in exc", intMask, 1);
    finishFetch(32'h0000_4000); cyc();
    chk("R12 mask clear", intMask, 0);
    // R4: watchdog in exec, bus released and exception modes
    curTag = "R4"; wdtOvf = 1'b1; cyc(); wdtOvf = 1'b0;
    chk("R4 from exec", procState, 0);
    cyc(); finishFetch(32'h0000_5000);
    busReq = 1'b1; cyc(); wdtOvf = 1'b1; cyc(); wdtOvf = 1'b0; busReq = 1'b0;
    chk("R4 from busrel", procState, 0);
    cyc(2); wdtOvf = 1'b1; cyc(); wdtOvf = 1'b0;
    chk("R4 from exception", procState, 0);
    cyc(2); finishFetch(32'h0000_6000); cyc();
    // R2: asynchronous reset between edges
    curTag = "R2"; rstN = 1'b0; #1;
    chk("R2 async mode", procState, 0);
    chk("R2 async mask", intMask, 1);
    chk("R2 async halt", coreHalt, 1);
    cyc(2); rstN = 1'b1; curTag = "R3"; cyc(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule